// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the 16-bit basic control word of an Ethernet PHY management register set. A management front end that has already decoded the serial frame and the register address presents a write strobe with write data; the block returns the current register image on a read data bus every cycle. From the stored value it drives the PHY's mode controls: loopback, 100/10 Mbps speed select, auto-negotiation enable, low-power mode, isolate, full/half duplex and collision test. It also raises single-cycle pulses that start a software reset and restart auto-negotiation.

A write with bit 15 set begins a software reset. The control fields return to their reset values at once. Bit 15 stays visible as 1 and a busy flag is raised. Every management write is dropped until an internal sequence of a parameterised length has run and the PHY core reports done. Then bit 15 clears itself. The reset value of the isolate field comes from the strapped 5-bit PHY address: it is 1 only when the address is zero.

Top module: `phy_ctrl_reg`

## Requirements
- R1: After hardware reset, `rdata_o` is 0x3000 when `phy_addr_i` is non-zero and 0x3400 when it is 00000, `busy_o` is 0 and both pulse outputs are 0.
- R2: A write with bit 15 clear stores bits 14 (loopback), 13 (speed, 1 = 100 Mbps), 12 (auto-negotiation enable), 11 (low power), 10 (isolate), 8 (duplex, 1 = full) and 7 (collision test). The new value appears on `rdata_o` and on the matching mode output in the cycle after the write edge.
- R3: Bits 6 to 0 always read 0, and writing 1s to them changes nothing.
- R4: A write with bit 9 = 1 raises `an_restart_o` for exactly the one cycle after the write edge, and bit 9 reads 1 in that cycle only. A write with bit 9 = 0 raises no pulse.
- R5: A write with bit 15 = 1 raises `sw_reset_o` for the one cycle after the write edge, sets `busy_o`, and reloads every control field with its R1 reset value (isolate from the current `phy_addr_i`).
- R6: While `busy_o` is 1, `rdata_o` reads 0x8000.
- R7: Writes that arrive while `busy_o` is 1 are discarded.
- R8: With `core_done_i` high, `busy_o` stays high for exactly RST_CYCLES cycles (16 by default). If `core_done_i` is low when the count expires, `busy_o` stays high until the first edge at which `core_done_i` is high.
- R9: In the cycle after `busy_o` falls, `rdata_o` shows the reset value with bit 15 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| phy_addr_i | input | 5 | Strapped PHY address, which sets the isolate reset value |
| wr_en_i | input | 1 | Write strobe for this register |
| wdata_i | input | 16 | Write data |
| core_done_i | input | 1 | PHY core reports that its internal reset has finished |
| rdata_o | output | 16 | Current register image |
| busy_o | output | 1 | Software reset in progress; accesses locked |
| loopback_o | output | 1 | Loopback enable |
| speed_100_o | output | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| an_enable_o | output | 1 | Auto-negotiation enable |
| low_power_o | output | 1 | Low-power mode |
| isolate_o | output | 1 | Isolate the PHY from the MAC interface |
| full_duplex_o | output | 1 | 1 = full duplex, 0 = half duplex |
| col_test_o | output | 1 | Collision test enable |
| sw_reset_o | output | 1 | One-cycle software reset pulse |
| an_restart_o | output | 1 | One-cycle auto-negotiation restart pulse |

## Verification
A wrong sequencer count shows on `busy_o` and on the 0x8000 read image. It moves the edge where `busy_o` falls, and the bench sees that in the same cycle. A field register that takes a write while locked, or that misses its reload, shows on the first read after `busy_o` falls and on the mode pins in that same cycle. A pulse that is late, stuck or missing shows on `sw_reset_o` or `an_restart_o`, and on read bit 9, one cycle after the write edge.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned B_RST   = 15;
  localparam int unsigned B_LOOP  = 14;
  localparam int unsigned B_SPEED = 13;
  localparam int unsigned B_ANEN  = 12;
  localparam int unsigned B_LPWR  = 11;
  localparam int unsigned B_ISO   = 10;
  localparam int unsigned B_ANRS  = 9;
  localparam int unsigned B_DUPX  = 8;
  localparam int unsigned B_COLT  = 7;

  // bits held in storage flops
  localparam logic [REG_W-1:0] STORE_MASK = 16'h7D80;
  localparam logic [REG_W-1:0] BUSY_IMAGE = 16'h8000;

  function automatic logic [REG_W-1:0] reset_value(input logic [ADDR_W-1:0] addr);
    logic [REG_W-1:0] v;
    v = '0;
    v[B_SPEED] = 1'b1;
    v[B_ANEN]  = 1'b1;
    v[B_ISO]   = (addr == '0);
    return v;
  endfunction
endpackage

// File: rtl/phy_ctrl_rstseq.sv
module phy_ctrl_rstseq #(
  parameter int unsigned RST_CYCLES = 16,
  parameter bit          USE_DONE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o,
  output logic pulse_o
);
  localparam int unsigned CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic          busy_q, busy_n;
  logic          pulse_q, pulse_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_ok;

  generate
    if (USE_DONE) begin : g_ext_done
      assign done_ok = done_i;
    end else begin : g_no_done
      assign done_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    busy_n  = busy_q;
    cnt_n   = cnt_q;
    pulse_n = 1'b0;
    if (start_i) begin
      busy_n  = 1'b1;
      cnt_n   = '0;
      pulse_n = 1'b1;
    end else if (busy_q) begin
      if (cnt_q != LAST) begin
        cnt_n = cnt_q + 1'b1;
      end else if (done_ok) begin
        busy_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      busy_q  <= busy_n;
      pulse_q <= pulse_n;
      cnt_q   <= cnt_n;
    end
  end

  assign busy_o  = busy_q;
  assign pulse_o = pulse_q;

  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == LAST) && $past(done_ok));
  p_pulse_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> busy_q);
endmodule

// File: rtl/phy_ctrl_fields.sv
module phy_ctrl_fields
  import phy_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             load_dflt_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] dflt_i,
  output logic [REG_W-1:0] fields_o,
  output logic             an_restart_o
);
  logic [REG_W-1:0] q_q, q_n;
  logic             anr_q, anr_n;

  always_comb begin
    q_n   = q_q;
    anr_n = 1'b0;
    if (load_dflt_i) begin
      q_n = dflt_i & STORE_MASK;
    end else if (wr_i) begin
      q_n   = wdata_i & STORE_MASK;
      anr_n = wdata_i[B_ANRS];
    end
  end

  // strap pins are static, so the reset value taken from them is stable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= dflt_i & STORE_MASK;
      anr_q <= 1'b0;
    end else begin
      q_q   <= q_n;
      anr_q <= anr_n;
    end
  end

  assign fields_o     = q_q;
  assign an_restart_o = anr_q;

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(q_q));
  p_restart_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(anr_q) |-> $past(wr_i) && $past(wdata_i[B_ANRS]));
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 16,
  parameter bit          USE_DONE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        phy_addr_i,
  input  logic              wr_en_i,
  input  logic [15:0]       wdata_i,
  input  logic              core_done_i,
  output logic [15:0]       rdata_o,
  output logic              busy_o,
  output logic              loopback_o,
  output logic              speed_100_o,
  output logic              an_enable_o,
  output logic              low_power_o,
  output logic              isolate_o,
  output logic              full_duplex_o,
  output logic              col_test_o,
  output logic              sw_reset_o,
  output logic              an_restart_o
);
  logic             busy;
  logic             start;
  logic             wr_ok;
  logic [REG_W-1:0] dflt;
  logic [REG_W-1:0] fields;
  logic             anr;

  assign dflt  = reset_value(phy_addr_i);
  assign start = wr_en_i && !busy && wdata_i[B_RST];
  assign wr_ok = wr_en_i && !busy && !wdata_i[B_RST];

  phy_ctrl_rstseq #(
    .RST_CYCLES (RST_CYCLES),
    .USE_DONE   (USE_DONE)
  ) i_rstseq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .done_i  (core_done_i),
    .busy_o  (busy),
    .pulse_o (sw_reset_o)
  );

  phy_ctrl_fields i_fields (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy),
    .load_dflt_i  (start),
    .wr_i         (wr_ok),
    .wdata_i      (wdata_i),
    .dflt_i       (dflt),
    .fields_o     (fields),
    .an_restart_o (anr)
  );

  always_comb begin
    if (busy) begin
      rdata_o = BUSY_IMAGE;
    end else begin
      rdata_o         = fields;
      rdata_o[B_ANRS] = anr;
    end
  end

  assign busy_o        = busy;
  assign an_restart_o  = anr;
  assign loopback_o    = fields[B_LOOP];
  assign speed_100_o   = fields[B_SPEED];
  assign an_enable_o   = fields[B_ANEN];
  assign low_power_o   = fields[B_LPWR];
  assign isolate_o     = fields[B_ISO];
  assign full_duplex_o = fields[B_DUPX];
  assign col_test_o    = fields[B_COLT];

  p_busy_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rdata_o == 16'h8000));
  p_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[6:0] == 7'd0);
  p_dflt_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (rdata_o == dflt));
endmodule

// File: tb/test_phy_ctrl_reg.sv
module test_phy_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  phy_addr_i;
  logic        wr_en_i;
  logic [15:0] wdata_i;
  logic        core_done_i;
  logic [15:0] rdata_o;
  logic        busy_o, loopback_o, speed_100_o, an_enable_o, low_power_o;
  logic        isolate_o, full_duplex_o, col_test_o, sw_reset_o, an_restart_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] rd;
    logic        busy;
    logic        swr;
    logic        anr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  phy_ctrl_reg i_phy_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .phy_addr_i(phy_addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .core_done_i(core_done_i), .rdata_o(rdata_o),
    .busy_o(busy_o), .loopback_o(loopback_o), .speed_100_o(speed_100_o),
    .an_enable_o(an_enable_o), .low_power_o(low_power_o), .isolate_o(isolate_o),
    .full_duplex_o(full_duplex_o), .col_test_o(col_test_o),
    .sw_reset_o(sw_reset_o), .an_restart_o(an_restart_o)
  );

  // monitor: compares the state visible in each cycle against the queue
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rdata_o !== e.rd || busy_o !== e.busy || sw_reset_o !== e.swr ||
          an_restart_o !== e.anr) begin
        fails++;
        $display("FAIL %s: rdata/busy/swr/anr = %h/%b/%b/%b expected %h/%b/%b/%b",
                 e.tag, rdata_o, busy_o, sw_reset_o, an_restart_o,
                 e.rd, e.busy, e.swr, e.anr);
      end
    end
  end

  // driver: one cycle, drives inputs and pushes what this cycle must show
  task automatic cyc(input logic we, input logic [15:0] d, input logic [15:0] er,
                     input logic eb, input logic es, input logic ea, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en_i = we;
    wdata_i = d;
    e.rd = er; e.busy = eb; e.swr = es; e.anr = ea; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic check_modes(input logic [6:0] exp, input string tag);
    logic [6:0] act;
    @(negedge clk);
    #2;
    act = {loopback_o, speed_100_o, an_enable_o, low_power_o, isolate_o,
           full_duplex_o, col_test_o};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: mode pins %b expected %b", tag, act, exp);
    end
  endtask

  task automatic hw_reset(input logic [4:0] addr);
    @(negedge clk);
    rst_n = 1'b0;
    phy_addr_i = addr;
    wr_en_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; phy_addr_i = 5'd0; wr_en_i = 1'b0; wdata_i = '0; core_done_i = 1'b1;
    // R1 address zero strap -> isolate set
    hw_reset(5'd0);
    cyc(0, 16'h0, 16'h3400, 0, 0, 0, "R1 addr0");
    check_modes(7'b0110100, "R1 addr0 modes");
    // R1 non-zero address
    hw_reset(5'd3);
    cyc(0, 16'h0, 16'h3000, 0, 0, 0, "R1 addr3");

    // R2/R3 field write with reserved bits set
    cyc(1, 16'h49FF, 16'h3000, 0, 0, 0, "R2 before edge");
    cyc(0, 16'h0,    16'h4980, 0, 0, 0, "R2 R3 readback");
    check_modes(7'b1001011, "R2 modes");

    // R4 restart pulse with other fields
    cyc(1, 16'h2600, 16'h4980, 0, 0, 0, "R4 write");
    cyc(0, 16'h0,    16'h2600, 0, 0, 1, "R4 pulse");
    cyc(0, 16'h0,    16'h2400, 0, 0, 0, "R4 self clear");
    cyc(1, 16'h2500, 16'h2400, 0, 0, 0, "R2 write");
    cyc(0, 16'h0,    16'h2500, 0, 0, 0, "R4 bit9 zero no pulse");
    check_modes(7'b0100110, "R2 modes 2");

    // R5..R9 software reset, writes ignored while busy
    cyc(1, 16'hC000, 16'h2500, 0, 0, 0, "R5 start");
    for (int i = 0; i < 16; i++) begin
      cyc((i % 3) == 1, 16'h4180, 16'h8000, 1, (i == 0), 0,
          (i == 0) ? "R5 pulse" : "R6 R7 R8 busy");
    end
    cyc(0, 16'h0, 16'h3000, 0, 0, 0, "R8 R9 release");
    check_modes(7'b0110000, "R5 R7 modes defaults");

    // R8 done held low extends busy
    cyc(1, 16'h0180, 16'h3000, 0, 0, 0, "R2 write");
    @(negedge clk); core_done_i = 1'b0;
    wr_en_i = 1'b0;
    begin
      exp_t e;
      e.rd = 16'h0180; e.busy = 0; e.swr = 0; e.anr = 0; e.tag = "R2 readback";
      sb.push_back(e);
    end
    cyc(1, 16'h8000, 16'h0180, 0, 0, 0, "R5 start 2");
    for (int i = 0; i < 20; i++) begin
      cyc(0, 16'h0, 16'h8000, 1, (i == 0), 0, "R8 busy held by done");
    end
    @(negedge clk); core_done_i = 1'b1;
    begin
      exp_t e;
      e.rd = 16'h8000; e.busy = 1; e.swr = 0; e.anr = 0; e.tag = "R8 done rises";
      sb.push_back(e);
    end
    cyc(0, 16'h0, 16'h3000, 0, 0, 0, "R8 R9 release after done");
    cyc(0, 16'h0, 16'h3000, 0, 0, 0, "R9 stable");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule